// File: doc/BRIEF.md
# Byte-Accessed Counter With Snapshot

This block is a 16-bit free-running up-counter that serves as the common timebase for a set of compare/capture channels. Software reaches it over a byte-wide register bus with three locations: the low count byte, the high count byte and a control byte. The count advances by one on each pulse of a selected count source. The sources are the system clock undivided, divided by 4 or divided by 12; a single-cycle overflow pulse from a neighbouring timer; falling edges on an external pin; and rising edges of an external oscillator that has already been divided by eight. Both external signals are resynchronised to the system clock first. All sources are single-cycle enables in the system clock domain, so the block has exactly one clock.

To read the 16-bit value coherently, software reads the low byte first. That read copies the high byte into a snapshot register, and the next high-byte read returns the snapshot. When the count wraps from 0xFFFF to 0x0000, a sticky overflow flag is set. An interrupt line follows the flag whenever the interrupt-enable bit is set. A run bit gates counting. A freeze bit makes the counter pause while the CPU reports idle.

Top module: `snap_timebase`

## Requirements
- R1: After reset the count is 0x0000, the snapshot is 0x00, the control byte reads 0x00 and `irq` is 0.
- R2: A bus write to address 0 loads the low count byte, and a write to address 1 loads the high count byte. A write in the same cycle as a count pulse takes priority, and that pulse is lost.
- R3: A read at address 0 returns the live low byte and, at that clock edge, copies the live high byte into the snapshot. A read at address 1 returns the snapshot, not the live high byte. Reads never change the count or delay its advance.
- R4: Control bits [5:3] select the source. 000 gives one count every 12 system clocks, 001 one every 4, and 100 one per system clock. The codes 110 and 111 hold the count.
- R5: Source code 010 adds one count for each single-cycle pulse on `aux_ovf`.
- R6: Source code 011 adds one count for each high-to-low transition of `ext_pin`, after a two-flop synchronizer. This is exact when transitions are at least four system clocks apart.
- R7: Source code 101 adds one count for each low-to-high transition of `ext_osc`, after a two-flop synchronizer.
- R8: A wrap from 0xFFFF to 0x0000 sets the overflow flag (control bit 7). Writing the control byte with bit 7 at 0 clears the flag, and writing it with bit 7 at 1 leaves the flag unchanged. When a wrap and a clearing write fall in the same cycle, the flag is set.
- R9: `irq` is 1 exactly while the overflow flag and the interrupt-enable bit (control bit 1) are both 1. Raising `irq` does not clear the flag.
- R10: While the run bit (control bit 0) is 0, the count does not advance.
- R11: When the freeze bit (control bit 2) is 1, the count does not advance while `cpu_idle` is 1. When the freeze bit is 0, `cpu_idle` has no effect. Control bit 6 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 low count, 1 high count/snapshot, 2 control |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle (latches the snapshot on a low-byte read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| aux_ovf | input | 1 | Single-cycle overflow pulse from another timer, synchronous to clk |
| ext_pin | input | 1 | Asynchronous external count input (falling edges counted) |
| ext_osc | input | 1 | Asynchronous external oscillator divided by eight (rising edges counted) |
| cpu_idle | input | 1 | High while the CPU is idle |
| count_val | output | 16 | Live count value to the compare/capture channels |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `aux_ovf` is already a single-cycle pulse synchronous to `clk`. They also assume that the bus asserts at most one of read or write in a cycle, at one address. The bench drives only such bus cycles, one strobe at a time, always from the falling clock edge. It spaces `ext_pin` falling edges eight cycles apart and `ext_osc` edges ten cycles apart, well inside the four-cycle limit. It measures prescaled sources over windows that are whole multiples of the divisor, so that the free-running divider phase cannot change the expected count.

// File: rtl/snap_timebase_pkg.sv
// Shared types for the snapshot timebase: source codes, bus addresses and
// control-byte bit positions. Assumes an 8-bit data bus.
package snap_timebase_pkg;

    typedef enum logic [2:0] {
        SRC_DIV12    = 3'b000,
        SRC_DIV4     = 3'b001,
        SRC_AUX      = 3'b010,
        SRC_PIN_FALL = 3'b011,
        SRC_SYSCLK   = 3'b100,
        SRC_OSC8     = 3'b101,
        SRC_RSV6     = 3'b110,
        SRC_RSV7     = 3'b111
    } src_e;

    localparam logic [1:0] ADDR_CNT_LO = 2'd0;
    localparam logic [1:0] ADDR_CNT_HI = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    localparam int CB_RUN    = 0;
    localparam int CB_IE     = 1;
    localparam int CB_FREEZE = 2;
    localparam int CB_SRC_LO = 3;
    localparam int CB_SRC_HI = 5;
    localparam int CB_FLAG   = 7;

endpackage

// File: rtl/pulse_div.sv
// Free-running prescaler: emits a one-cycle enable pulse every DIV clocks.
// Assumes DIV >= 2; the phase starts at reset and is never restarted.
module pulse_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Step the phase counter and wrap it at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign pulse = (phase == LAST);

    // R4: a prescaled pulse never lasts two consecutive cycles
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/sync_edge.sv
// Multi-flop synchronizer followed by an edge detector. FALLING selects
// which transition gives the one-cycle pulse. Assumes din is asynchronous
// and changes no faster than the system clock can sample.
module sync_edge #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_pulse
);
    logic [STAGES-1:0] sh;
    logic              prev;

    // Shift the input through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], din};
            prev <= sh[STAGES-1];
        end
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_pulse = prev & ~sh[STAGES-1];
        end else begin : g_rise
            assign edge_pulse = ~prev & sh[STAGES-1];
        end
    endgenerate

    // R6: a detected edge is a pulse of exactly one cycle
    a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/tick_mux.sv
// Builds every count source as a one-cycle enable in the clk domain and
// selects one with the source code. Reserved codes give no tick.
module tick_mux
    import snap_timebase_pkg::*;
#(
    parameter int SLOW_DIV    = 12,
    parameter int FAST_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic aux_ovf,
    input  logic ext_pin,
    input  logic ext_osc,
    output logic tick
);
    logic slow_p, fast_p, pin_p, osc_p;

    pulse_div #(.DIV(SLOW_DIV)) i_div_slow (.clk(clk), .rst_n(rst_n), .pulse(slow_p));
    pulse_div #(.DIV(FAST_DIV)) i_div_fast (.clk(clk), .rst_n(rst_n), .pulse(fast_p));

    sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) i_pin_edge (
        .clk(clk), .rst_n(rst_n), .din(ext_pin), .edge_pulse(pin_p));
    sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) i_osc_edge (
        .clk(clk), .rst_n(rst_n), .din(ext_osc), .edge_pulse(osc_p));

    // Pick the enable that belongs to the selected source.
    always_comb begin
        unique case (src)
            SRC_DIV12:    tick = slow_p;
            SRC_DIV4:     tick = fast_p;
            SRC_AUX:      tick = aux_ovf;
            SRC_PIN_FALL: tick = pin_p;
            SRC_SYSCLK:   tick = 1'b1;
            SRC_OSC8:     tick = osc_p;
            default:      tick = 1'b0;
        endcase
    end

    // R4: the reserved codes never produce a count pulse
    a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_RSV6 || src == SRC_RSV7) |-> !tick);

    // R5: with the auxiliary source selected, pulses come only from aux_ovf
    a_r5_aux_only: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_AUX && !aux_ovf) |-> !tick);

endmodule

// File: rtl/count_core.sv
// The count register with byte loads and the high-byte snapshot. Assumes
// at most one of the write/read strobes per cycle. A byte write takes
// priority over an increment in the same cycle.
module count_core #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                rd_lo,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic [BYTE_W-1:0]   snap,
    output logic                wrap
);
    localparam int CNT_W = 2 * BYTE_W;

    logic any_wr;
    assign any_wr = wr_lo | wr_hi;

    // Load a byte on a write, otherwise advance on an accepted pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_lo) cnt[BYTE_W-1:0]     <= wdata;
        else if (wr_hi) cnt[CNT_W-1:BYTE_W] <= wdata;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    // Copy the live high byte into the snapshot on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)     snap <= '0;
        else if (rd_lo) snap <= cnt[CNT_W-1:BYTE_W];
    end

    assign wrap = inc & ~any_wr & (&cnt);

    // R2: a low-byte write lands even while a count pulse is present
    a_r2_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt[BYTE_W-1:0] == $past(wdata));
    // R2: a high-byte write leaves the low byte alone
    a_r2_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (cnt[CNT_W-1:BYTE_W] == $past(wdata)) &&
                  (cnt[BYTE_W-1:0] == $past(cnt[BYTE_W-1:0])));
    // R3: the snapshot holds the high byte seen at the low-byte read
    a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> snap == $past(cnt[CNT_W-1:BYTE_W]));
    // R3: reads do not disturb counting
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !any_wr) |=> cnt == $past(cnt) + 1'b1);
    // R10: without a pulse or write the count holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !any_wr) |=> $stable(cnt));

endmodule

// File: rtl/ctrl_bank.sv
// Control byte: run, interrupt enable, freeze, source code and the sticky
// overflow flag. Software can clear the flag but never set it, and a
// hardware wrap wins over a clear in the same cycle.
module ctrl_bank
    import snap_timebase_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wrap,
    output logic              run,
    output logic              ie,
    output logic              freeze,
    output src_e              src,
    output logic              flag,
    output logic              irq
);
    // Load the writable fields from a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            ie     <= 1'b0;
            freeze <= 1'b0;
            src    <= SRC_DIV12;
        end else if (wr_ctrl) begin
            run    <= wdata[CB_RUN];
            ie     <= wdata[CB_IE];
            freeze <= wdata[CB_FREEZE];
            src    <= src_e'(wdata[CB_SRC_HI:CB_SRC_LO]);
        end
    end

    // Set the flag on a wrap; clear it only on a write with the bit at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (wrap)                       flag <= 1'b1;
        else if (wr_ctrl && !wdata[CB_FLAG]) flag <= 1'b0;
    end

    assign irq = flag & ie;

    // R8: a wrap always leaves the flag set
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);
    // R8: the flag only drops through a control write
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_ctrl) |=> flag);
    // R8: software cannot raise the flag
    a_r8_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !wrap) |=> !flag);

endmodule

// File: rtl/snap_timebase.sv
// Top level of the snapshot timebase: decodes the byte bus, forms the
// count enable from source, run and idle freeze, and muxes read data.
// Assumes a single read or write strobe per cycle and a synchronous aux_ovf.
module snap_timebase
    import snap_timebase_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SLOW_DIV    = 12,
    parameter int FAST_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                aux_ovf,
    input  logic                ext_pin,
    input  logic                ext_osc,
    input  logic                cpu_idle,
    output logic [2*BYTE_W-1:0] count_val,
    output logic                irq
);
    localparam int CNT_W = 2 * BYTE_W;

    logic              wr_lo, wr_hi, wr_ctrl, rd_lo;
    logic              run, ie, freeze, flag, tick, inc, wrap;
    src_e              src;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] snap;

    assign wr_lo   = bus_wr && bus_addr == ADDR_CNT_LO;
    assign wr_hi   = bus_wr && bus_addr == ADDR_CNT_HI;
    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
    assign rd_lo   = bus_rd && bus_addr == ADDR_CNT_LO;

    tick_mux #(
        .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .SYNC_STAGES(SYNC_STAGES)
    ) i_tick_mux (
        .clk(clk), .rst_n(rst_n), .src(src), .aux_ovf(aux_ovf),
        .ext_pin(ext_pin), .ext_osc(ext_osc), .tick(tick)
    );

    assign inc = tick & run & ~(freeze & cpu_idle);

    count_core #(.BYTE_W(BYTE_W)) i_count_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .rd_lo(rd_lo), .wdata(bus_wdata), .cnt(cnt), .snap(snap), .wrap(wrap)
    );

    ctrl_bank #(.BYTE_W(BYTE_W)) i_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
        .wrap(wrap), .run(run), .ie(ie), .freeze(freeze), .src(src),
        .flag(flag), .irq(irq)
    );

    // Return the register selected by the address.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
            ADDR_CNT_HI: bus_rdata = snap;
            ADDR_CTRL: begin
                bus_rdata[CB_RUN]               = run;
                bus_rdata[CB_IE]                = ie;
                bus_rdata[CB_FREEZE]            = freeze;
                bus_rdata[CB_SRC_HI:CB_SRC_LO]  = src;
                bus_rdata[CB_FLAG]              = flag;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign count_val = cnt;

    // R10: a cleared run bit stops the count (unless software loads it)
    a_r10_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(count_val));
    // R11: freeze with idle asserted holds the count
    a_r11_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && cpu_idle && !bus_wr) |=> $stable(count_val));
    // R9: the interrupt line follows the flag and its enable
    a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ie));

endmodule

// File: tb/test_snap_timebase.sv
// Self-checking bench: a vector table of source/gating cases, then
// directed tests for reset, snapshot, priority, external sources, overflow.
module test_snap_timebase;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // columns: src, run, freeze, idle, cycles, expected count
    localparam int VEC [NVEC][6] = '{
        '{0, 1, 0, 0, 24, 2},
        '{1, 1, 0, 0, 24, 6},
        '{4, 1, 0, 0, 20, 20},
        '{6, 1, 0, 0, 20, 0},
        '{7, 1, 0, 0, 20, 0},
        '{4, 0, 0, 0, 20, 0},
        '{4, 1, 1, 1, 20, 0},
        '{4, 1, 0, 1, 20, 20},
        '{4, 1, 1, 0, 20, 20},
        '{1, 1, 0, 0, 48, 12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        aux_ovf = 1'b0;
    logic        ext_pin = 1'b1;
    logic        ext_osc = 1'b0;
    logic        cpu_idle = 1'b0;
    logic [15:0] count_val;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snap_timebase i_snap_timebase (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .aux_ovf(aux_ovf), .ext_pin(ext_pin), .ext_osc(ext_osc),
        .cpu_idle(cpu_idle), .count_val(count_val), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        reg_rd(2'd0, lo);
        reg_rd(2'd1, hi);
        v = {hi, lo};
    endtask

    // control byte: flag bit kept at 1 so writes never clear the flag
    function automatic logic [7:0] mk(input int src, input bit run, input bit frz, input bit ie);
        return {1'b1, 1'b0, 3'(src), frz, ie, run};
    endfunction

    task automatic run_for(input logic [7:0] on, input logic [7:0] off, input int n);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = on; bus_wr = 1'b1;
        repeat (n) @(negedge clk);
        bus_wdata = off;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic clear_count();
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        reg_rd(2'd2, b); chk("R1 ctrl", {8'd0, b}, 16'h0000);
        rd16(v);         chk("R1 count", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R4 R10 R11: vector table of sources and gating
        for (int i = 0; i < NVEC; i++) begin
            clear_count();
            cpu_idle = VEC[i][3][0];
            run_for(mk(VEC[i][0], VEC[i][1][0], VEC[i][2][0], 1'b0),
                    mk(VEC[i][0], 1'b0, VEC[i][2][0], 1'b0), VEC[i][4]);
            rd16(v);
            chk($sformatf("R4/R10/R11 vector %0d", i), v, 16'(VEC[i][5]));
        end
        cpu_idle = 1'b0;

        // R3: snapshot returns the high byte seen at the low read
        reg_wr(2'd1, 8'h12);
        reg_wr(2'd0, 8'hFF);
        reg_rd(2'd0, b); chk("R3 live low", {8'd0, b}, 16'h00FF);
        reg_wr(2'd1, 8'h34);
        reg_rd(2'd1, b); chk("R3 snapshot", {8'd0, b}, 16'h0012);
        chk("R2 high loaded", count_val, 16'h34FF);
        rd16(v);         chk("R3 fresh pair", v, 16'h34FF);

        // R3: reads during counting do not disturb it
        clear_count();
        reg_wr(2'd2, mk(4, 1'b1, 1'b0, 1'b0));
        reg_rd(2'd0, b); reg_rd(2'd0, b); reg_rd(2'd0, b);
        reg_wr(2'd2, mk(4, 1'b0, 1'b0, 1'b0));
        rd16(v);         chk("R3 reads undisturbed", v, 16'd8);

        // R2: write wins over a same-cycle increment
        clear_count();
        reg_wr(2'd2, mk(4, 1'b1, 1'b0, 1'b0));
        reg_wr(2'd0, 8'h50);
        reg_wr(2'd2, mk(4, 1'b0, 1'b0, 1'b0));
        rd16(v);         chk("R2 write priority", v, 16'h0052);

        // R5: auxiliary overflow pulses
        clear_count();
        reg_wr(2'd2, mk(2, 1'b1, 1'b0, 1'b0));
        for (int k = 0; k < 7; k++) begin
            @(negedge clk); aux_ovf = 1'b1;
            @(negedge clk); aux_ovf = 1'b0;
            @(negedge clk);
        end
        reg_wr(2'd2, mk(2, 1'b0, 1'b0, 1'b0));
        rd16(v);         chk("R5 aux pulses", v, 16'd7);

        // R6: falling edges on the external pin
        clear_count();
        reg_wr(2'd2, mk(3, 1'b1, 1'b0, 1'b0));
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); ext_pin = 1'b0;
            repeat (4) @(negedge clk);
            ext_pin = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        reg_wr(2'd2, mk(3, 1'b0, 1'b0, 1'b0));
        rd16(v);         chk("R6 pin falling edges", v, 16'd5);

        // R7: rising edges of the divided external oscillator
        clear_count();
        reg_wr(2'd2, mk(5, 1'b1, 1'b0, 1'b0));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ext_osc = 1'b1;
            repeat (5) @(negedge clk);
            ext_osc = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        reg_wr(2'd2, mk(5, 1'b0, 1'b0, 1'b0));
        rd16(v);         chk("R7 osc edges", v, 16'd4);

        // R8 R9: wrap, interrupt, sticky flag and clearing
        reg_wr(2'd1, 8'hFF);
        reg_wr(2'd0, 8'hFE);
        run_for(mk(4, 1'b1, 1'b0, 1'b1), mk(4, 1'b0, 1'b0, 1'b1), 3);
        rd16(v);         chk("R8 wrapped count", v, 16'h0001);
        reg_rd(2'd2, b); chk("R8 flag set", {8'd0, b}, 16'h00A2);
        chk("R9 irq raised", {15'd0, irq}, 16'h0001);
        reg_wr(2'd2, mk(4, 1'b0, 1'b0, 1'b0));
        chk("R9 irq masked", {15'd0, irq}, 16'h0000);
        reg_rd(2'd2, b); chk("R8 write one keeps flag", {8'd0, b}, 16'h00A0);
        reg_wr(2'd2, 8'h02);
        reg_rd(2'd2, b); chk("R8 flag cleared", {8'd0, b}, 16'h0002);
        chk("R9 irq low after clear", {15'd0, irq}, 16'h0000);
        reg_wr(2'd2, 8'h80);
        reg_rd(2'd2, b); chk("R8 no software set", {8'd0, b}, 16'h0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule